// File: doc/BRIEF.md
# Halting DMA Bus-Grant Controller

This block decides which of two masters drives a single RAM port: the CPU datapath or one external DMA peripheral, such as a front-panel switch unit. The peripheral raises an asynchronous request line. The controller synchronises that line and looks at it only when the CPU sequencer flags an instruction-fetch boundary, the same point where a pending interrupt would be taken. When the request is taken, the controller stalls the sequencer, switches the RAM address, write data and write enable over to the peripheral, and raises an acknowledge. It holds that state until the request goes away.

Only one mode exists: the CPU halts outright for the whole session. No cycles are stolen and no execution overlaps the transfer. When the request is released, acknowledge drops first. One dead cycle follows in which no master may write. Then the CPU gets the bus back and completes the fetch it was held on. After a session, the CPU always gets at least one instruction in before the next grant.

The block has no streaming data path. All of its pins are plain control and bus signals with no valid/ready handshake, so there are no back-pressure rules to state.

Top module: `dma_halt_arbiter`

## Requirements
- R1: While reset is asserted (asynchronous, active low), and right after it, `dma_ack` and `stall` are 0 and the RAM port carries the CPU address, data and write enable. This holds even if reset arrives in the middle of a DMA session.
- R2: A synchronised request seen when `fetch_boundary` is 0 is not taken: `stall` and `dma_ack` stay 0 and the CPU keeps the RAM port.
- R3: The request passes through a two-flop synchroniser. A request that has been high for fewer than two rising clock edges is not taken, even with `fetch_boundary` at 1.
- R4: When the synchronised request is 1 at a cycle with `fetch_boundary` at 1, the controller takes it. `stall` goes to 1 in that same cycle. The CPU's write in that cycle still reaches the RAM. `dma_ack` rises on the following clock edge, on the same edge as the bus switch.
- R5: While `dma_ack` is 1, `stall` is 1 and `ram_addr`, `ram_wdata` and `ram_we` equal `dev_addr`, `dev_wdata` and `dev_we`.
- R6: The service state holds for as long as the synchronised request stays 1, whatever `fetch_boundary` does.
- R7: On the first edge after the synchronised request is 0, `dma_ack` falls. Exactly one dead cycle follows in which `stall` is 1 and `ram_we` is 0 even if either master asserts a write. On the next edge the CPU owns the port and `stall` is 0.
- R8: After a session ends, the first `fetch_boundary` cycle is never granted, even with the request held high. The next boundary cycle may be granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req_async | input | 1 | DMA request from the peripheral, asynchronous |
| fetch_boundary | input | 1 | Sequencer is at an instruction-fetch boundary |
| cpu_addr | input | ADDR_W | CPU address bus |
| cpu_wdata | input | DATA_W | CPU memory data register output |
| cpu_we | input | 1 | CPU RAM write enable |
| dev_addr | input | ADDR_W | Peripheral address |
| dev_wdata | input | DATA_W | Peripheral write data |
| dev_we | input | 1 | Peripheral RAM write enable |
| stall | output | 1 | Freezes the CPU sequencer |
| dma_ack | output | 1 | Bus granted to the peripheral |
| ram_addr | output | ADDR_W | Muxed RAM address |
| ram_wdata | output | DATA_W | Muxed RAM write data |
| ram_we | output | 1 | Muxed RAM write enable |

## Verification
Each fault in the controller state shows up at the ports within a cycle or two.
- A grant state entered too early shows up as `dma_ack` rising with no boundary one cycle before.
- A grant state that is not left shows up as `dma_ack` staying high three edges after the request port has dropped.
- A missing dead cycle shows up as a CPU write reaching `ram_we` on the very cycle after `dma_ack` falls.
- A lost forward-progress flag shows up as a grant, signalled by `stall` rising in the same cycle, at the first boundary after a session.
- A synchroniser stage that is too short or too long moves the first grant by one cycle in either direction, and the cycle-exact vector walk catches that shift.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    OWN_CPU = 2'd0,
    OWN_DEV = 2'd1,
    DEAD    = 2'd2
  } owner_t;
endpackage

// File: rtl/req_sync.sv
module req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain[LAST];
endmodule

// File: rtl/grant_fsm.sv
module grant_fsm
  import dma_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic fetch_boundary,
  output logic stall,
  output logic grant,
  output logic dead
);
  owner_t state, state_nx;
  logic   hold_off;
  logic   take;

  // A grant needs a boundary and a synced request, and no pending forward-progress hold.
  assign take = (state == OWN_CPU) && fetch_boundary && req_s && !hold_off;

  always_comb begin
    state_nx = state;
    case (state)
      OWN_CPU: if (take)   state_nx = OWN_DEV;
      OWN_DEV: if (!req_s) state_nx = DEAD;
      DEAD:                state_nx = OWN_CPU;
      default:             state_nx = OWN_CPU;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= OWN_CPU;
      hold_off <= 1'b0;
    end else begin
      state <= state_nx;
      if (state != OWN_CPU)
        hold_off <= 1'b1;
      else if (fetch_boundary)
        hold_off <= 1'b0;
    end
  end

  assign stall = (state != OWN_CPU) || take;
  assign grant = (state == OWN_DEV);
  assign dead  = (state == DEAD);
endmodule

// File: rtl/ram_port_mux.sv
module ram_port_mux #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              sel_dev,
  input  logic              dead,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [DATA_W-1:0] dev_wdata,
  input  logic              dev_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we
);
  always_comb begin
    if (sel_dev) begin
      ram_addr  = dev_addr;
      ram_wdata = dev_wdata;
      ram_we    = dev_we;
    end else begin
      ram_addr  = cpu_addr;
      ram_wdata = cpu_wdata;
      ram_we    = cpu_we && !dead;
    end
  end
endmodule

// File: rtl/dma_halt_arbiter.sv
module dma_halt_arbiter #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_req_async,
  input  logic              fetch_boundary,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [DATA_W-1:0] dev_wdata,
  input  logic              dev_we,
  output logic              stall,
  output logic              dma_ack,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we
);
  logic req_seen;
  logic dead;

  req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (dma_req_async),
    .q_sync  (req_seen)
  );

  grant_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_s          (req_seen),
    .fetch_boundary (fetch_boundary),
    .stall          (stall),
    .grant          (dma_ack),
    .dead           (dead)
  );

  ram_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .sel_dev   (dma_ack),
    .dead      (dead),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .dev_addr  (dev_addr),
    .dev_wdata (dev_wdata),
    .dev_we    (dev_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .ram_we    (ram_we)
  );
endmodule

// File: rtl/dma_halt_arbiter_chk.sv
module dma_halt_arbiter_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_seen,
  input logic              fetch_boundary,
  input logic              stall,
  input logic              dma_ack,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] dev_addr,
  input logic [DATA_W-1:0] dev_wdata,
  input logic              dev_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [DATA_W-1:0] ram_wdata,
  input logic              ram_we
);
  AST_NO_GRANT_MIDINSTR: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_ack && !stall) |=> !dma_ack); // R2
  AST_GRANT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_ack) |-> ($past(fetch_boundary) && $past(stall))); // R4
  AST_DEV_OWNS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ack |-> (stall && ram_addr == dev_addr && ram_wdata == dev_wdata && ram_we == dev_we)); // R5
  AST_HOLD_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_ack && req_seen) |=> dma_ack); // R6
  AST_DEAD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_ack) |-> (stall && !ram_we)); // R7
  AST_CPU_OWNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> (ram_addr == cpu_addr && ram_we == cpu_we)); // R1
endmodule

bind dma_halt_arbiter dma_halt_arbiter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_seen       (req_seen),
  .fetch_boundary (fetch_boundary),
  .stall          (stall),
  .dma_ack        (dma_ack),
  .cpu_addr       (cpu_addr),
  .cpu_we         (cpu_we),
  .dev_addr       (dev_addr),
  .dev_wdata      (dev_wdata),
  .dev_we         (dev_we),
  .ram_addr       (ram_addr),
  .ram_wdata      (ram_wdata),
  .ram_we         (ram_we)
);

// File: tb/sim_dma_halt_arbiter.sv
`timescale 1ns/1ps
module sim_dma_halt_arbiter;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam logic [AW-1:0] CA = 16'h1a2b;
  localparam logic [AW-1:0] DA = 16'hc3d4;
  localparam logic [DW-1:0] CD = 8'h5e;
  localparam logic [DW-1:0] DD = 8'h71;
  localparam int NV = 23;
  // {req, boundary, cpu_we, dev_we, exp_stall, exp_ack, exp_ram_we, exp_dev_src, tag[3:0]}
  localparam logic [11:0] VEC [NV] = '{
    12'b0010_0010_0001, // R1 idle after reset, cpu write passes
    12'b1100_0000_0011, // R3 req not yet synced
    12'b1100_0000_0011, // R3 one stage only
    12'b1010_0010_0010, // R2 synced, no boundary
    12'b1000_0000_0010, // R2
    12'b1110_1010_0100, // R4 taken: stall now, cpu write completes
    12'b1110_1101_0101, // R5 ack, device owns
    12'b1011_1111_0101, // R5 device write
    12'b0001_1111_0110, // R6 port dropped, sync still high
    12'b0101_1111_0110, // R6 boundary ignored
    12'b0011_1111_0110, // R6 last service cycle
    12'b0011_1000_0111, // R7 dead cycle, no write
    12'b1010_0010_0111, // R7 cpu back; req re-raised
    12'b1000_0000_1000, // R8
    12'b1100_0000_1000, // R8 first boundary refused
    12'b1000_0000_1000, // R8
    12'b1100_1000_1000, // R8 second boundary granted
    12'b1001_1111_0101, // R5
    12'b0000_1101_0110, // R6
    12'b0000_1101_0110, // R6
    12'b0000_1101_0110, // R6
    12'b0010_1000_0111, // R7 dead cycle
    12'b0010_0010_0111  // R7 cpu owns
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, bnd = 1'b0, cwe = 1'b0, dwe = 1'b0;
  logic stall, ack, rwe;
  logic [AW-1:0] raddr;
  logic [DW-1:0] rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dma_halt_arbiter #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .dma_req_async(req), .fetch_boundary(bnd),
    .cpu_addr(CA), .cpu_wdata(CD), .cpu_we(cwe),
    .dev_addr(DA), .dev_wdata(DD), .dev_we(dwe),
    .stall(stall), .dma_ack(ack), .ram_addr(raddr), .ram_wdata(rdata), .ram_we(rwe)
  );

  task automatic chk(input int tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input int tag, input logic es, input logic ea, input logic ew, input logic src);
    chk(tag, "stall", 32'(stall), 32'(es));
    chk(tag, "dma_ack", 32'(ack), 32'(ea));
    chk(tag, "ram_we", 32'(rwe), 32'(ew));
    chk(tag, "ram_addr", 32'(raddr), src ? 32'(DA) : 32'(CA));
    chk(tag, "ram_wdata", 32'(rdata), src ? 32'(DD) : 32'(CD));
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      {req, bnd, cwe, dwe} = VEC[i][11:8];
      #1;
      chk_all(int'(VEC[i][3:0]), VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4]);
      @(posedge clk); #1;
    end
    // R5 then R1: reset in the middle of a session
    req = 1'b1; bnd = 1'b1; cwe = 1'b1; dwe = 1'b0;
    repeat (3) begin @(posedge clk); #1; end
    chk_all(5, 1'b1, 1'b1, 1'b0, 1'b1);
    rst_n = 1'b0; #1;
    chk_all(1, 1'b0, 1'b0, 1'b1, 1'b0); // R1 async reset frees the port
    @(posedge clk); #1;
    req = 1'b0; rst_n = 1'b1;
    @(posedge clk); #1;
    chk_all(1, 1'b0, 1'b0, 1'b1, 1'b0); // R1 stays idle after release
    done = 1'b1;
    report();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule